// File: doc/BRIEF.md
# Display RAM Host Bus Holder

This block joins an 8-bit parallel host bus to a single-port display RAM through one holding register. Writes are posted. A data write loads the holding register when the write strobe rises. In the next clock cycle the register is written into RAM at the current column address, and the address then steps on by one. The host never waits for the RAM.

Reads are pipelined through the same register. During a read strobe the host sees what the register already holds. When the strobe rises, the RAM word at the current address is fetched into the register and the address steps on by one. The first read after an address-set command or after a data write therefore returns stale data, and the word for the new address appears on the second read. Host signals are sampled on the block clock. A strobe takes effect when its rising edge is seen, using the chip select, A0 and data values sampled while the strobe was still low.

Top module: `dram_bus_holder`

## Requirements
- R1: While chip select (`cs_n`) is high, strobes, A0 and bus data have no effect: the address, the holding register and the RAM keep their contents.
- R2: While `cs_n` is high, the block never drives `hbus`, even with `rd_n` low.
- R3: `hbus` is driven only while `cs_n` is low, `rd_n` is low and `a0` is 1, and the value driven is the holding register. A read strobe with `a0` = 0 leaves the bus undriven and changes nothing.
- R4: The rising edge of a data write strobe (`a0` = 1) loads the holding register with the bus byte. In the following clock cycle that byte is written to RAM at the current address, and the address then increments by one.
- R5: The rising edge of a data read strobe fetches the RAM word at the current address into the holding register and increments the address. The first read after an address set therefore returns the previous holder contents, and the second read returns the word at the set address.
- R6: The first read after a data write returns the byte just written.
- R7: A write with `a0` = 0 is a command. Byte `0x0n` sets the low 4 address bits to n, and byte `0x1n` sets the high address bits to the low bits of n. Any other command byte leaves the address unchanged.
- R8: The address wraps from its maximum value (0xFF by default) to 0, for both writes and reads.
- R9: After reset the holding register is 0, the address is 0 and the bus is released.
- R10: Each strobe needs only one clock low and one clock high. Back-to-back writes at that rate are all stored, with no wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; host signals are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | 0 = command, 1 = display data |
| rd_n | input | 1 | Read strobe, active low; acts on its rising edge |
| wr_n | input | 1 | Write strobe, active low; acts on its rising edge |
| hbus | inout | 8 | Bidirectional host data bus |

## Verification
The assertions assume the host meets the cycle-time rule. Every strobe stays low for at least one clock and high for at least one clock, so a new edge never arrives while a commit or fetch is in flight. They also assume the host never drops both strobes at once, and that it holds `cs_n`, `a0` and write data steady from the clock before a rising strobe edge until after it. The bench drives every signal on the falling clock edge. It keeps chip select, A0 and data one cycle past each strobe rise, and its fastest burst uses exactly one clock low and one clock high per write. Because `hbus` is a pulled-up net in the bench, a released bus reads 0xFF, so all test data avoids that value.

// File: rtl/dbh_pkg.sv
package dbh_pkg;

    localparam int BUS_W = 8;
    localparam int NIB_W = 4;

    typedef logic [BUS_W-1:0] bus_byte_t;

    // kind of host access recognised at a strobe's trailing edge
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_CMD   = 2'd1,
        EV_WDATA = 2'd2,
        EV_RDATA = 2'd3
    } bus_ev_e;

    typedef struct packed {
        bus_ev_e   kind;
        bus_byte_t data;
    } bus_event_t;

    // holding register sequencer
    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_COMMIT = 2'd1,
        HS_FETCH  = 2'd2
    } hold_state_e;

    typedef enum logic [1:0] {
        CMD_ADDR_LO = 2'd0,
        CMD_ADDR_HI = 2'd1,
        CMD_OTHER   = 2'd2
    } cmd_kind_e;

    function automatic cmd_kind_e decode_cmd(input bus_byte_t b);
        cmd_kind_e k;
        case (b[BUS_W-1:NIB_W])
            4'h0:    k = CMD_ADDR_LO;
            4'h1:    k = CMD_ADDR_HI;
            default: k = CMD_OTHER;
        endcase
        return k;
    endfunction

    function automatic logic [NIB_W-1:0] cmd_nibble(input bus_byte_t b);
        return b[NIB_W-1:0];
    endfunction

endpackage

// File: rtl/dbh_bus_sense.sv
module dbh_bus_sense
    import dbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       a0,
    input  logic       rd_n,
    input  logic       wr_n,
    input  bus_byte_t  din,
    output bus_event_t ev
);

    logic      cs_q;
    logic      a0_q;
    logic      rd_q;
    logic      wr_q;
    bus_byte_t din_q;

    // values seen one cycle earlier, while a strobe was still low
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            a0_q  <= 1'b0;
            rd_q  <= 1'b1;
            wr_q  <= 1'b1;
            din_q <= '0;
        end else begin
            cs_q  <= cs_n;
            a0_q  <= a0;
            rd_q  <= rd_n;
            wr_q  <= wr_n;
            din_q <= din;
        end
    end

    logic wr_rise;
    logic rd_rise;

    assign wr_rise = wr_n && !wr_q;
    assign rd_rise = rd_n && !rd_q;

    always_comb begin
        ev.kind = EV_NONE;
        ev.data = din_q;
        if (!cs_q) begin
            if (wr_rise) begin
                ev.kind = a0_q ? EV_WDATA : EV_CMD;
            end else if (rd_rise && a0_q) begin
                ev.kind = EV_RDATA;
            end
        end
    end

endmodule

// File: rtl/dbh_addr_ctr.sv
module dbh_addr_ctr
    import dbh_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_lo,
    input  logic              set_hi,
    input  logic [NIB_W-1:0]  nib,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);

    localparam int HI_W = ADDR_W - NIB_W;

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (set_lo) begin
            addr_q[NIB_W-1:0] <= nib;
        end else if (set_hi) begin
            addr_q[ADDR_W-1:NIB_W] <= nib[HI_W-1:0];
        end else if (inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/dbh_holder_ctl.sv
module dbh_holder_ctl
    import dbh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_event_t  ev,
    input  bus_byte_t   ram_rdata,
    output hold_state_e state,
    output bus_byte_t   holder,
    output logic        ram_we,
    output logic        ram_re,
    output logic        addr_inc,
    output logic        set_lo,
    output logic        set_hi
);

    hold_state_e st_q;
    bus_byte_t   hold_q;
    cmd_kind_e   ck;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= HS_IDLE;
            hold_q <= '0;
        end else begin
            case (st_q)
                HS_IDLE: begin
                    if (ev.kind == EV_WDATA) begin
                        hold_q <= ev.data;
                        st_q   <= HS_COMMIT;
                    end else if (ev.kind == EV_RDATA) begin
                        st_q   <= HS_FETCH;
                    end
                end
                HS_COMMIT: st_q <= HS_IDLE;
                HS_FETCH: begin
                    hold_q <= ram_rdata;
                    st_q   <= HS_IDLE;
                end
                default: st_q <= HS_IDLE;
            endcase
        end
    end

    always_comb begin
        ck       = decode_cmd(ev.data);
        ram_we   = (st_q == HS_COMMIT);
        ram_re   = (st_q == HS_IDLE) && (ev.kind == EV_RDATA);
        addr_inc = ram_we || ram_re;
        set_lo   = (ev.kind == EV_CMD) && (ck == CMD_ADDR_LO);
        set_hi   = (ev.kind == EV_CMD) && (ck == CMD_ADDR_HI);
    end

    assign state  = st_q;
    assign holder = hold_q;

endmodule

// File: rtl/dbh_ram.sv
module dbh_ram
    import dbh_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  bus_byte_t         wdata,
    output bus_byte_t         rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    bus_byte_t mem [DEPTH];
    bus_byte_t rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else if (re) begin
            rd_q <= mem[addr];
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/dram_bus_holder.sv
module dram_bus_holder
    import dbh_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       a0,
    input  logic       rd_n,
    input  logic       wr_n,
    inout  wire  [7:0] hbus
);

    bus_event_t        ev;
    hold_state_e       state;
    bus_byte_t         holder;
    bus_byte_t         ram_rdata;
    logic              ram_we;
    logic              ram_re;
    logic              addr_inc;
    logic              set_lo;
    logic              set_hi;
    logic [ADDR_W-1:0] addr;
    logic              drive_en;

    dbh_bus_sense u_sense (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .a0   (a0),
        .rd_n (rd_n),
        .wr_n (wr_n),
        .din  (hbus),
        .ev   (ev)
    );

    dbh_holder_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .ram_rdata (ram_rdata),
        .state     (state),
        .holder    (holder),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .addr_inc  (addr_inc),
        .set_lo    (set_lo),
        .set_hi    (set_hi)
    );

    dbh_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .set_lo (set_lo),
        .set_hi (set_hi),
        .nib    (cmd_nibble(ev.data)),
        .inc    (addr_inc),
        .addr   (addr)
    );

    dbh_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (addr),
        .wdata (holder),
        .rdata (ram_rdata)
    );

    assign drive_en = !cs_n && !rd_n && a0;
    assign hbus     = drive_en ? holder : 'z;

endmodule

// File: rtl/dbh_checker.sv
module dbh_checker
    import dbh_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input bus_event_t        ev,
    input hold_state_e       state,
    input bus_byte_t         holder,
    input bus_byte_t         ram_rdata,
    input logic              ram_we,
    input logic              ram_re,
    input logic [ADDR_W-1:0] addr
);

    // R1
    cs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && state == HS_IDLE) |=> ($stable(addr) && $stable(holder)));

    // R4
    post_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == HS_IDLE && ev.kind == EV_WDATA) |=> (ram_we && holder == $past(ev.data)));

    // R4
    commit_step_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> (addr == $past(addr) + 1'b1));

    // R5
    fetch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (state == HS_FETCH) |=> (holder == $past(ram_rdata)));

    // R5
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        ram_re |=> (state == HS_FETCH && addr == $past(addr) + 1'b1));

    // R7
    other_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (state == HS_IDLE && ev.kind == EV_CMD && decode_cmd(ev.data) == CMD_OTHER)
        |=> $stable(addr));

    // R10
    ram_port_chk: assert property (@(posedge clk) disable iff (rst)
        !(ram_we && ram_re));

endmodule

bind dram_bus_holder dbh_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .ev        (ev),
    .state     (state),
    .holder    (holder),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .addr      (addr)
);

// File: tb/sim_dram_bus_holder.sv
`timescale 1ns/1ps
module sim_dram_bus_holder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       a0 = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       hd_en = 1'b0;
    logic [7:0] hd_drv = 8'h00;
    tri1  [7:0] hbus;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    assign hbus = hd_en ? hd_drv : 'z;

    always #10 clk = ~clk;

    dram_bus_holder u0 (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .a0   (a0),
        .rd_n (rd_n),
        .wr_n (wr_n),
        .hbus (hbus)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one strobe cycle; strobe low two clocks, bus sampled just before it rises
    task automatic bus_cycle(input bit sel, input bit a0v, input bit is_rd,
                             input logic [7:0] wdata, output logic [7:0] rdata);
        @(negedge clk);
        cs_n = !sel;
        a0   = a0v;
        if (is_rd) begin
            hd_en = 1'b0;
            rd_n  = 1'b0;
        end else begin
            hd_en  = 1'b1;
            hd_drv = wdata;
            wr_n   = 1'b0;
        end
        repeat (2) @(negedge clk);
        rdata = hbus;
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        @(negedge clk);
        cs_n  = 1'b1;
        hd_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b);
        logic [7:0] d;
        bus_cycle(1'b1, 1'b0, 1'b0, b, d);
    endtask

    task automatic set_addr(input logic [7:0] ad);
        cmd({4'h1, ad[7:4]});
        cmd({4'h0, ad[3:0]});
    endtask

    task automatic wr(input logic [7:0] b);
        logic [7:0] d;
        bus_cycle(1'b1, 1'b1, 1'b0, b, d);
    endtask

    task automatic rd(output logic [7:0] b);
        bus_cycle(1'b1, 1'b1, 1'b1, 8'h00, b);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R9 bus idle", hbus, 8'hFF);
        rd(v);
        check("R9 holder cleared", v, 8'h00);
        wr(8'h5A);            // address was 0, read moved it to 1
        rd(v);
        check("R6 write then dummy", v, 8'h5A);
        set_addr(8'h01);
        rd(v);
        rd(v);
        check("R9 address from zero", v, 8'h5A);
    endtask

    task automatic t_write_seq();
        logic [7:0] v;
        set_addr(8'h20);
        wr(8'h11);
        wr(8'h22);
        wr(8'h33);
        wr(8'h44);
        rd(v);
        check("R6 dummy after write", v, 8'h44);
        set_addr(8'h20);
        rd(v);
        rd(v);
        check("R4 word 0", v, 8'h11);
        rd(v);
        check("R4 word 1", v, 8'h22);
        set_addr(8'h23);
        rd(v);
        check("R5 stale after set", v, 8'h33);
        rd(v);
        check("R5 valid second read", v, 8'h44);
    endtask

    // one clock low and one clock high per write
    task automatic t_burst();
        logic [7:0] v;
        set_addr(8'h50);
        @(negedge clk);
        cs_n  = 1'b0;
        a0    = 1'b1;
        hd_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            hd_drv = 8'h60 + 8'(i);
            wr_n   = 1'b0;
            @(negedge clk);
            wr_n = 1'b1;
            @(negedge clk);
        end
        cs_n  = 1'b1;
        hd_en = 1'b0;
        repeat (2) @(negedge clk);
        set_addr(8'h50);
        rd(v);
        for (int i = 0; i < 4; i++) begin
            rd(v);
            check("R10 burst word", v, 8'h60 + 8'(i));
        end
    endtask

    task automatic t_cmd_decode();
        logic [7:0] v;
        set_addr(8'h30);
        wr(8'hA1);
        wr(8'hA2);
        set_addr(8'h30);
        cmd(8'hB7);
        cmd(8'h25);
        rd(v);
        rd(v);
        check("R7 other cmds ignored", v, 8'hA1);
        cmd(8'h01);           // low nibble only: 0x31
        rd(v);
        rd(v);
        check("R7 low nibble set", v, 8'hA2);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        set_addr(8'hFF);
        wr(8'hF0);
        wr(8'h0E);
        set_addr(8'hFF);
        rd(v);
        rd(v);
        check("R8 last address", v, 8'hF0);
        rd(v);
        check("R8 wrapped to zero", v, 8'h0E);
    endtask

    task automatic t_cs_and_bus();
        logic [7:0] v;
        set_addr(8'h40);
        wr(8'h77);
        bus_cycle(1'b0, 1'b0, 1'b0, 8'h00, v);
        bus_cycle(1'b0, 1'b0, 1'b0, 8'h10, v);
        bus_cycle(1'b0, 1'b1, 1'b0, 8'h99, v);
        bus_cycle(1'b0, 1'b1, 1'b1, 8'h00, v);
        check("R2 released with cs high", v, 8'hFF);
        wr(8'h66);            // must land at 0x41
        set_addr(8'h40);
        rd(v);
        check("R1 holder kept", v, 8'h66);
        rd(v);
        check("R1 ram kept", v, 8'h77);
        bus_cycle(1'b1, 1'b0, 1'b1, 8'h00, v);
        check("R3 no drive on command read", v, 8'hFF);
        rd(v);
        check("R3 drives holder", v, 8'h66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_seq();
        t_burst();
        t_cmd_decode();
        t_wrap();
        t_cs_and_bus();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule